// File: doc/BRIEF.md
# Magic Packet Wake-Up Capture

This block sits beside a receive MAC and inspects every frame that streams past on a byte-wide interface with start, end, valid and good-frame strobes. While wake-up detection is armed, it looks for a magic pattern aimed at the station address supplied on an input port. When a frame that carries the pattern ends cleanly, the block keeps the opening bytes of that frame, raises a sticky status flag and, if software asked for it, asserts a one-cycle power-management event request.

The captured frame stays frozen until software acknowledges it by writing one to the status flag. A small word-addressed register port reaches the control word, the status word, the captured length and the capture buffer. A separate configuration load strobe copies an enable value from non-volatile initialization data into the control word at power-up, and again on any later reload.

Top module: `wake_capture_top`

## Requirements
- R1: After synchronous reset the control word (offset 0) and status word (offset 1) read as zero and `pme_req` is low.
- R2: A cycle with `nv_load` high copies `nv_wake_en` into control bit 0 (wake enable); a load of 0 clears an enable that was set before.
- R3: A frame matches when it holds at least six consecutive 0xFF bytes immediately followed by sixteen back-to-back copies of the station address, sent from `station_addr[47:40]` down to `station_addr[7:0]`; after a broken copy the search restarts, and a 0xFF byte that breaks a copy counts as the first sync byte.
- R4: No match is recorded while control bit 0 is clear, whether it was cleared by a register write or by a configuration load.
- R5: A matching frame that ends with `rx_good` low leaves the status word and the captured length unchanged.
- R6: A recorded match sets status bit 0 (wake frame received).
- R7: On a recorded match the buffer holds the first min(length, 128) bytes of that frame, readable one byte per word at offset 0x80 + index in bits 7:0, and the length word (offset 2) reads min(length, 128).
- R8: While status bit 0 is set, further matching frames change neither the buffer, nor the length word, nor raise a new event.
- R9: Status bits are write-one-to-clear: a 0 in a written bit leaves it alone, and clearing bit 0 re-arms capture for the next match.
- R10: When control bit 1 (event on wake) is set, a recorded match sets status bit 1 and drives `pme_req` high for exactly one cycle; with bit 1 clear, neither happens.
- R11: Register read data appears on `reg_rdata` in the cycle after the `reg_rd` strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nv_load | input | 1 | Strobe: copy configuration enable into control bit 0 |
| nv_wake_en | input | 1 | Enable value from non-volatile initialization data |
| station_addr | input | 48 | Station address to match, first wire byte in bits 47:40 |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of frame (with rx_valid) |
| rx_eof | input | 1 | Last byte of frame (with rx_valid) |
| rx_good | input | 1 | Frame ended without error (sampled with rx_eof) |
| rx_data | input | 8 | Receive byte |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| pme_req | output | 1 | One-cycle power-management event request |

## Verification
The bench keeps the default parameters: six sync bytes, sixteen address copies and a 128-byte buffer. With those values the shortest magic frame is 102 bytes, so frames that end below the buffer size, exactly at 128 bytes and well beyond it all carry a full pattern. This lets one stimulus table reach the short-capture, exact-fill and truncation cases along with the restart paths in the matcher.

// File: rtl/wake_pkg.sv
// Shared types and register layout of the wake capture unit.
package wake_pkg;
    // One received byte together with its framing strobes.
    typedef struct packed {
        logic       valid;
        logic       sof;
        logic       eof;
        logic       good;
        logic [7:0] data;
    } rx_beat_t;

    // Word offsets in the register port (buffer lives at top half).
    localparam int REG_CTRL = 0;
    localparam int REG_STAT = 1;
    localparam int REG_LEN  = 2;

    // Bit positions.
    localparam int CTRL_EN  = 0;
    localparam int CTRL_PME = 1;
    localparam int ST_MAGIC = 0;
    localparam int ST_PME   = 1;
endpackage

// File: rtl/wake_magic_detect.sv
// Magic pattern matcher.
// Scans the byte stream for SYNC_LEN or more 0xFF bytes directly followed
// by ADDR_COPIES copies of the station address. hit_now reports, for the
// beat on the input, whether the current frame has matched so far
// (including that beat). Assumes sof only comes with valid and that the
// station address never starts with 0xFF (true for unicast addresses).
module wake_magic_detect
    import wake_pkg::*;
#(
    parameter int SYNC_LEN    = 6,
    parameter int ADDR_COPIES = 16,
    parameter int ADDR_BYTES  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  rx_beat_t                  beat,
    input  logic [8*ADDR_BYTES-1:0]   station_addr,
    output logic                      hit_now
);
    localparam int FF_W  = $clog2(SYNC_LEN + 1);
    localparam int PTR_W = $clog2(ADDR_BYTES);
    localparam int CPY_W = $clog2(ADDR_COPIES);

    logic [7:0]       addr_byte [ADDR_BYTES];
    logic [FF_W-1:0]  ff_cnt,  ff_n;
    logic             in_match, match_n;
    logic [PTR_W-1:0] ptr,     ptr_n;
    logic [CPY_W-1:0] copy,    copy_n;
    logic             found,   found_n;
    logic             done;

    // Split the address into wire-order bytes.
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
        assign addr_byte[g] = station_addr[8*(ADDR_BYTES-1-g) +: 8];
    end

    // Next-state of the matcher for the beat on the input.
    always_comb begin
        ff_n    = beat.sof ? '0 : ff_cnt;
        match_n = beat.sof ? 1'b0 : in_match;
        ptr_n   = beat.sof ? '0 : ptr;
        copy_n  = beat.sof ? '0 : copy;
        found_n = beat.sof ? 1'b0 : found;
        done    = 1'b0;
        if (beat.valid) begin
            if (match_n) begin
                if (beat.data == addr_byte[ptr_n]) begin
                    if (ptr_n == PTR_W'(ADDR_BYTES - 1)) begin
                        ptr_n = '0;
                        if (copy_n == CPY_W'(ADDR_COPIES - 1)) begin
                            done    = 1'b1;
                            match_n = 1'b0;
                            copy_n  = '0;
                        end else begin
                            copy_n = copy_n + CPY_W'(1);
                        end
                    end else begin
                        ptr_n = ptr_n + PTR_W'(1);
                    end
                end else begin
                    match_n = 1'b0;
                    ptr_n   = '0;
                    copy_n  = '0;
                    ff_n    = (beat.data == 8'hFF) ? FF_W'(1) : '0;
                end
            end else if (beat.data == 8'hFF) begin
                if (ff_n != FF_W'(SYNC_LEN)) ff_n = ff_n + FF_W'(1);
            end else if (ff_n == FF_W'(SYNC_LEN) && beat.data == addr_byte[0]) begin
                match_n = 1'b1;
                ptr_n   = PTR_W'(1);
                copy_n  = '0;
                ff_n    = '0;
            end else begin
                ff_n = '0;
            end
            if (done) found_n = 1'b1;
        end
        hit_now = found_n;
    end

    // Register the matcher state on every valid beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ff_cnt   <= '0;
            in_match <= 1'b0;
            ptr      <= '0;
            copy     <= '0;
            found    <= 1'b0;
        end else if (beat.valid) begin
            ff_cnt   <= ff_n;
            in_match <= match_n;
            ptr      <= ptr_n;
            copy     <= copy_n;
            found    <= found_n;
        end
    end

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        in_match |-> (int'(ptr) < ADDR_BYTES)); // R3
    AST_SYNC_CLEAR_IN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        in_match |-> (ff_cnt == '0)); // R3
endmodule

// File: rtl/wake_capture_buf.sv
// Capture store for the opening bytes of each frame.
// Writes each byte at its frame position while not frozen, up to DEPTH
// bytes, and latches the byte count on commit. Reads are registered.
// Assumes commit is only raised on an end-of-frame beat and never while
// frozen.
module wake_capture_buf
    import wake_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rx_beat_t         beat,
    input  logic             frozen,
    input  logic             commit,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte,
    output logic [LEN_W-1:0] cap_len
);
    logic [7:0]       mem [DEPTH];
    logic [LEN_W-1:0] wr_cnt, pos, cnt_n;
    logic             room;

    // Position of the current byte and the count after it.
    always_comb begin
        pos   = beat.sof ? '0 : wr_cnt;
        room  = pos < LEN_W'(DEPTH);
        cnt_n = room ? pos + LEN_W'(1) : pos;
    end

    // Byte counter within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)          wr_cnt <= '0;
        else if (beat.valid) wr_cnt <= cnt_n;
    end

    // Store bytes while the buffer is open.
    always_ff @(posedge clk) begin
        if (beat.valid && !frozen && room) mem[pos[IDX_W-1:0]] <= beat.data;
    end

    // Registered buffer read.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_byte <= '0;
        else if (rd_en) rd_byte <= mem[rd_idx];
    end

    // Captured length, taken when a match is committed.
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_len <= '0;
        else if (commit) cap_len <= cnt_n;
    end

    AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cap_len) <= DEPTH); // R7
    AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(cap_len)); // R8
endmodule

// File: rtl/wake_regs.sv
// Control and status registers plus the read mux.
// Holds wake enable and event enable, the sticky wake and event status
// bits (write-one-to-clear), the event pulse, and registered read data.
// Assumes commit is already qualified by wake enable and by a clear
// wake status bit.
module wake_regs
    import wake_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              nv_load,
    input  logic              nv_wake_en,
    input  logic              commit,
    input  logic [LEN_W-1:0]  cap_len,
    input  logic [7:0]        buf_byte,
    output logic              wake_en,
    output logic              status_magic,
    output logic              pme_req,
    output logic [31:0]       reg_rdata
);
    logic        pme_en, pme_status;
    logic        wr_ctrl, wr_stat;
    logic        rd_buf;
    logic [31:0] rd_word;
    logic        unused_wdata;

    assign unused_wdata = &{1'b0, reg_wdata[31:2]};
    assign wr_ctrl = reg_wr && reg_addr == REG_AW'(REG_CTRL);
    assign wr_stat = reg_wr && reg_addr == REG_AW'(REG_STAT);

    // Control word: configuration load wins over a register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_en <= 1'b0;
            pme_en  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                wake_en <= reg_wdata[CTRL_EN];
                pme_en  <= reg_wdata[CTRL_PME];
            end
            if (nv_load) wake_en <= nv_wake_en;
        end
    end

    // Sticky status bits: set by a match, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_magic <= 1'b0;
            pme_status   <= 1'b0;
        end else begin
            if (commit)                            status_magic <= 1'b1;
            else if (wr_stat && reg_wdata[ST_MAGIC]) status_magic <= 1'b0;
            if (commit && pme_en)                  pme_status   <= 1'b1;
            else if (wr_stat && reg_wdata[ST_PME]) pme_status   <= 1'b0;
        end
    end

    // One-cycle event request.
    always_ff @(posedge clk) begin
        if (!rst_n) pme_req <= 1'b0;
        else        pme_req <= commit && pme_en;
    end

    // Registered register read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_buf  <= 1'b0;
            rd_word <= '0;
        end else if (reg_rd) begin
            rd_buf <= reg_addr[REG_AW-1];
            if (reg_addr == REG_AW'(REG_CTRL))      rd_word <= {30'b0, pme_en, wake_en};
            else if (reg_addr == REG_AW'(REG_STAT)) rd_word <= {30'b0, pme_status, status_magic};
            else if (reg_addr == REG_AW'(REG_LEN))  rd_word <= 32'(cap_len);
            else                                    rd_word <= '0;
        end
    end

    assign reg_rdata = rd_buf ? {24'b0, buf_byte} : rd_word;

    AST_PME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pme_req |=> !pme_req); // R10
    AST_PME_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        pme_req |-> (pme_status && status_magic)); // R10
    AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_magic) |-> $past(wake_en)); // R4
    AST_W1C_MAGIC: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[ST_MAGIC] && status_magic) |=> !status_magic); // R9
endmodule

// File: rtl/wake_capture_top.sv
// Magic packet wake-up capture unit, top level.
// Ties the matcher, capture store and register block together and forms
// the commit condition: good end of frame, match seen, wake enabled and
// no earlier capture pending. Assumes rx_sof/rx_eof/rx_good are only
// meaningful with rx_valid.
module wake_capture_top
    import wake_pkg::*;
#(
    parameter int CAP_DEPTH   = 128,
    parameter int SYNC_LEN    = 6,
    parameter int ADDR_COPIES = 16,
    parameter int REG_AW      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_load,
    input  logic              nv_wake_en,
    input  logic [47:0]       station_addr,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_good,
    input  logic [7:0]        rx_data,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              pme_req
);
    localparam int IDX_W = $clog2(CAP_DEPTH);
    localparam int LEN_W = $clog2(CAP_DEPTH + 1);

    rx_beat_t         beat;
    logic             hit_now, commit, wake_en, status_magic;
    logic [7:0]       buf_byte;
    logic [LEN_W-1:0] cap_len;

    assign beat   = '{valid: rx_valid, sof: rx_sof, eof: rx_eof, good: rx_good, data: rx_data};
    assign commit = rx_valid && rx_eof && rx_good && hit_now && wake_en && !status_magic;

    wake_magic_detect #(
        .SYNC_LEN(SYNC_LEN), .ADDR_COPIES(ADDR_COPIES), .ADDR_BYTES(6)
    ) u_detect (
        .clk(clk), .rst_n(rst_n), .beat(beat),
        .station_addr(station_addr), .hit_now(hit_now)
    );

    wake_capture_buf #(
        .DEPTH(CAP_DEPTH), .IDX_W(IDX_W), .LEN_W(LEN_W)
    ) u_buf (
        .clk(clk), .rst_n(rst_n), .beat(beat), .frozen(status_magic),
        .commit(commit), .rd_en(reg_rd && reg_addr[REG_AW-1]),
        .rd_idx(reg_addr[IDX_W-1:0]), .rd_byte(buf_byte), .cap_len(cap_len)
    );

    wake_regs #(
        .REG_AW(REG_AW), .LEN_W(LEN_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .nv_load(nv_load),
        .nv_wake_en(nv_wake_en), .commit(commit), .cap_len(cap_len),
        .buf_byte(buf_byte), .wake_en(wake_en), .status_magic(status_magic),
        .pme_req(pme_req), .reg_rdata(reg_rdata)
    );
endmodule

// File: tb/sim_wake_capture_top.sv
module sim_wake_capture_top;
    localparam logic [47:0] SA = 48'h02_11_22_33_44_55;
    // {kind[3:0], en, pme_en, good, exp_status, exp_len[7:0]}
    localparam logic [15:0] VEC [8] = '{
        {4'd0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd128},
        {4'd1, 1'b1, 1'b0, 1'b1, 1'b1, 8'd128},
        {4'd2, 1'b1, 1'b1, 1'b1, 1'b0, 8'd0},
        {4'd3, 1'b1, 1'b1, 1'b1, 1'b0, 8'd0},
        {4'd4, 1'b1, 1'b1, 1'b1, 1'b1, 8'd102},
        {4'd5, 1'b1, 1'b0, 1'b1, 1'b1, 8'd128},
        {4'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0},
        {4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0}
    };

    logic clk = 0, rst_n = 0, nv_load = 0, nv_wake_en = 0;
    logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_good = 0;
    logic [7:0] rx_data = 0;
    logic reg_wr = 0, reg_rd = 0;
    logic [7:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic pme_req;

    int errors = 0, checks = 0, pme_cnt = 0, flen = 0;
    logic [7:0] fbuf [256];

    always #4 clk = ~clk;

    wake_capture_top u0 (
        .clk(clk), .rst_n(rst_n), .nv_load(nv_load), .nv_wake_en(nv_wake_en),
        .station_addr(SA), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_good(rx_good), .rx_data(rx_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pme_req(pme_req)
    );

    always @(negedge clk) if (rst_n && pme_req) pme_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        @(negedge clk); reg_rd = 0; v = int'(reg_rdata);
    endtask

    task automatic put(input logic [7:0] b);
        fbuf[flen] = b; flen++;
    endtask

    task automatic put_ff(input int n);
        for (int i = 0; i < n; i++) put(8'hFF);
    endtask

    task automatic put_copies(input int n);
        for (int c = 0; c < n; c++)
            for (int j = 0; j < 6; j++) put(SA[8*(5-j) +: 8]);
    endtask

    task automatic build(input int kind);
        flen = 0;
        case (kind)
            0: begin
                for (int i = 0; i < 14; i++) put(8'(i + 1));
                put_ff(8); put_copies(16);
                for (int i = 0; i < 18; i++) put(8'(8'h20 + i));
            end
            1: begin
                for (int i = 0; i < 10; i++) put(8'(i + 1));
                put_ff(6); put_copies(5); put(8'h00); put_ff(6); put_copies(16);
            end
            2: begin
                for (int i = 0; i < 10; i++) put(8'(i + 1));
                put_ff(6); put_copies(15); put(8'h00);
                for (int i = 0; i < 6; i++) put(8'h30);
            end
            3: begin
                for (int i = 0; i < 10; i++) put(8'(i + 1));
                put_ff(5); put_copies(16);
                for (int i = 0; i < 4; i++) put(8'h40);
            end
            4: begin
                put_ff(6); put_copies(16);
            end
            default: begin
                put_ff(6); put_copies(3); put(SA[47:40]); put(SA[39:32]);
                put_ff(6); put_copies(16);
            end
        endcase
    endtask

    task automatic send(input logic good);
        for (int i = 0; i < flen; i++) begin
            @(negedge clk);
            rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == flen - 1);
            rx_good = good; rx_data = fbuf[i];
        end
        @(negedge clk); rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_good = 0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v, p0, len;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 R11: reset state, read one cycle after strobe
        rd(8'h00, v); chk("R1 R11 ctrl after reset", v, 0);
        rd(8'h01, v); chk("R1 status after reset", v, 0);
        chk("R1 pme_req after reset", int'(pme_req), 0);
        // R2: configuration load sets and clears enable
        @(negedge clk); nv_wake_en = 1; nv_load = 1;
        @(negedge clk); nv_load = 0;
        rd(8'h00, v); chk("R2 load enable 1", v, 1);
        @(negedge clk); nv_wake_en = 0; nv_load = 1;
        @(negedge clk); nv_load = 0;
        rd(8'h00, v); chk("R2 load enable 0", v, 0);

        // Table walk: R3 R5 R6 R7 R10 R4
        foreach (VEC[r]) begin
            wr(8'h01, 32'h3);
            wr(8'h00, {30'b0, VEC[r][10], VEC[r][11]});
            p0 = pme_cnt;
            build(int'(VEC[r][15:12]));
            send(VEC[r][9]);
            rd(8'h01, v);
            chk($sformatf("R3 R4 R5 R6 R10 row %0d status", r), v,
                {30'b0, VEC[r][8] & VEC[r][10], VEC[r][8]});
            chk($sformatf("R10 row %0d pme pulses", r), pme_cnt - p0,
                int'(VEC[r][8] & VEC[r][10]));
            if (VEC[r][8]) begin
                len = int'(VEC[r][7:0]);
                rd(8'h02, v); chk($sformatf("R7 row %0d length", r), v, len);
                rd(8'h80, v); chk($sformatf("R7 row %0d first byte", r), v, int'(fbuf[0]));
                rd(8'(8'h80 + len - 1), v);
                chk($sformatf("R7 row %0d last byte", r), v, int'(fbuf[len-1]));
            end
        end

        // R8: capture frozen while status set
        wr(8'h01, 32'h3); wr(8'h00, 32'h3);
        build(4); send(1'b1);
        rd(8'h02, v); chk("R7 short frame length", v, 102);
        p0 = pme_cnt;
        build(0); send(1'b1);
        rd(8'h02, v); chk("R8 length frozen", v, 102);
        rd(8'h80, v); chk("R8 byte 0 frozen", v, 8'hFF);
        rd(8'h80 + 101, v); chk("R8 byte 101 frozen", v, 8'h55);
        chk("R8 no second event", pme_cnt - p0, 0);

        // R9: write-one-to-clear
        wr(8'h01, 32'h0); rd(8'h01, v); chk("R9 write 0 no effect", v, 3);
        wr(8'h01, 32'h2); rd(8'h01, v); chk("R9 clear event bit only", v, 1);
        wr(8'h01, 32'h1); rd(8'h01, v); chk("R9 clear wake bit", v, 0);
        build(0); send(1'b1);
        rd(8'h01, v); chk("R9 re-armed status", v, 3);
        rd(8'h02, v); chk("R9 re-armed length", v, 128);
        rd(8'h80, v); chk("R9 re-armed byte 0", v, 1);

        // R4: software disable, then configuration reload clears enable
        wr(8'h01, 32'h3); wr(8'h00, 32'h2);
        build(4); send(1'b1);
        rd(8'h01, v); chk("R4 sw disabled no match", v, 0);
        wr(8'h00, 32'h3);
        @(negedge clk); nv_wake_en = 0; nv_load = 1;
        @(negedge clk); nv_load = 0;
        build(4); send(1'b1);
        rd(8'h01, v); chk("R4 R2 reload disabled no match", v, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule